// File: doc/BRIEF.md
# Masked Same-Page Address Detector

This block watches a memory bus and reports, for each access to one chosen chip-select region, whether the word address lies on the same memory page as the previous access to that region. A DRAM controller uses the flag to skip row activation and issue a column access at once. The page size is not fixed: software writes a bit mask, and only the address bits that the mask keeps are compared, so one design serves any row geometry.

A bus cycle begins on the clock where the active-low address strobe is sampled low while no cycle is open. It ends on the clock where the active-low ready input is sampled low. The active-low result is registered. It appears one clock after the strobe, stays put for the whole bus cycle, and returns high one clock after ready. A global enable bit gates the function. Clearing the enable forces the result high and discards the stored page. Setting it again means the next qualifying access starts fresh.

Top module: `page_match_detector`

## Requirements
- R1: While reset is asserted and after its release, `same_page_n` is 1, the mask holds all ones (every address bit compared) and the enable is 0.
- R2: While the enable bit is 0, `same_page_n` stays 1 whatever the bus does.
- R3: An access whose `region_sel_n` is 1 at its strobe never drives `same_page_n` low and leaves the stored previous address unchanged.
- R4: A qualifying access (enabled, `region_sel_n` 0 at the strobe) whose masked address equals the masked stored address drives `same_page_n` to 0 on the clock after the strobe is sampled.
- R5: Address bits whose mask bit is 0 are ignored in the comparison. A difference in any bit whose mask bit is 1 keeps `same_page_n` at 1.
- R6: Once low, `same_page_n` stays 0 until ready is sampled low, and it is 1 on the clock after that sample.
- R7: The first qualifying access after reset, or after the enable goes from 0 to 1, reports 1 (not same page).
- R8: Each qualifying access stores its own address as the new previous address once its own comparison is done, so that access is compared against the one before it.
- R9: A mask or enable write takes effect on the clock after it is sampled. Writing enable 0 during a bus cycle drives `same_page_n` to 1 on the next clock.
- R10: A strobe sampled low while a bus cycle is open is ignored. It starts no comparison and stores no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 26 | Word address, bits 27 down to 2 |
| strobe_n | input | 1 | Address strobe, active low |
| ready_n | input | 1 | End of bus cycle, active low |
| region_sel_n | input | 1 | Qualifying chip-select, active low |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 26 | New mask, 1 = bit compared |
| enable_wr | input | 1 | Enable bit write strobe |
| enable_wdata | input | 1 | New enable value |
| same_page_n | output | 1 | Same-page result, active low |

## Verification
The bound checker enforces four properties on every clock. A disabled detector never reports a hit. A non-qualifying strobe never produces a low output. The output falls only on the clock after a qualifying strobe. A low output holds until ready and then rises. Whether a given hit or miss is correct depends on the mask and on the address history: the masked compare, the fresh start after reset or re-enable, the update of the stored address and the ignored strobes inside a cycle. Only the bench shows these, by running a behavioural reference model alongside the design and checking directed scenarios.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef struct packed {
        logic busy;   // bus cycle open
        logic hit;    // same-page result held for the cycle
        logic valid;  // stored previous address is usable
    } trk_state_t;

    localparam trk_state_t TRK_RESET = '{busy: 1'b0, hit: 1'b0, valid: 1'b0};
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    input  logic         enable_wr,
    input  logic         enable_wdata,
    output logic [W-1:0] mask_q,
    output logic         en_q,
    output logic         en_d
);
    logic [W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        en_d   = en_q;
        if (mask_wr)   mask_d = mask_wdata;
        if (enable_wr) en_d   = enable_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            en_q   <= 1'b0;
        end else begin
            mask_q <= mask_d;
            en_q   <= en_d;
        end
    end
endmodule

// File: rtl/pm_masked_cmp.sv
module pm_masked_cmp #(
    parameter int W = 26
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] mask,
    output logic         match
);
    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_ok[i] = ~((cur[i] ^ prev[i]) & mask[i]);
    end

    assign match = &bit_ok;
endmodule

// File: rtl/pm_cycle_tracker.sv
module pm_cycle_tracker
    import pm_pkg::*;
#(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addr,
    input  logic         strobe_n,
    input  logic         ready_n,
    input  logic         region_sel_n,
    input  logic         en_q,
    input  logic         en_d,
    input  logic         match,
    output logic [W-1:0] prev_q,
    output logic         busy_q,
    output logic         hit_q
);
    trk_state_t   st_d, st_q;
    logic [W-1:0] prev_d;
    logic         start;

    assign start = !strobe_n && !st_q.busy;

    always_comb begin
        st_d   = st_q;
        prev_d = prev_q;
        if (start) begin
            st_d.busy = 1'b1;
            if (!region_sel_n && en_q) begin
                st_d.hit   = st_q.valid && match;
                prev_d     = addr;
                st_d.valid = 1'b1;
            end else begin
                st_d.hit = 1'b0;
            end
        end else if (st_q.busy && !ready_n) begin
            st_d.busy = 1'b0;
            st_d.hit  = 1'b0;
        end
        if (!en_d) begin
            st_d.hit   = 1'b0;
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TRK_RESET;
            prev_q <= '0;
        end else begin
            st_q   <= st_d;
            prev_q <= prev_d;
        end
    end

    assign busy_q = st_q.busy;
    assign hit_q  = st_q.hit;
endmodule

// File: rtl/page_match_detector.sv
module page_match_detector #(
    parameter int ADDR_MSB = 27,
    parameter int ADDR_LSB = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_MSB:ADDR_LSB] addr,
    input  logic                     strobe_n,
    input  logic                     ready_n,
    input  logic                     region_sel_n,
    input  logic                     mask_wr,
    input  logic [ADDR_MSB:ADDR_LSB] mask_wdata,
    input  logic                     enable_wr,
    input  logic                     enable_wdata,
    output logic                     same_page_n
);
    localparam int AW = ADDR_MSB - ADDR_LSB + 1;

    logic [AW-1:0] mask_q;
    logic [AW-1:0] prev_q;
    logic          en_q, en_d;
    logic          match;
    logic          busy_q, hit_q;

    pm_cfg_regs #(.W(AW)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_wr      (mask_wr),
        .mask_wdata   (mask_wdata),
        .enable_wr    (enable_wr),
        .enable_wdata (enable_wdata),
        .mask_q       (mask_q),
        .en_q         (en_q),
        .en_d         (en_d)
    );

    pm_masked_cmp #(.W(AW)) u_cmp (
        .cur   (addr),
        .prev  (prev_q),
        .mask  (mask_q),
        .match (match)
    );

    pm_cycle_tracker #(.W(AW)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .strobe_n     (strobe_n),
        .ready_n      (ready_n),
        .region_sel_n (region_sel_n),
        .en_q         (en_q),
        .en_d         (en_d),
        .match        (match),
        .prev_q       (prev_q),
        .busy_q       (busy_q),
        .hit_q        (hit_q)
    );

    assign same_page_n = ~hit_q;
endmodule

// File: rtl/pm_checker.sv
module pm_checker (
    input logic clk,
    input logic rst_n,
    input logic strobe_n,
    input logic ready_n,
    input logic region_sel_n,
    input logic enable_wr,
    input logic enable_wdata,
    input logic same_page_n,
    input logic en_q,
    input logic busy_q
);
    p_disabled_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> same_page_n);

    p_other_region_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !busy_q && region_sel_n) |=> same_page_n);

    p_fall_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(same_page_n) |-> $past(!strobe_n && !region_sel_n && !busy_q));

    p_hold_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!same_page_n && ready_n && !(enable_wr && !enable_wdata)) |=> !same_page_n);

    p_release_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !ready_n) |=> same_page_n);
endmodule

bind page_match_detector pm_checker u_pm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_n     (strobe_n),
    .ready_n      (ready_n),
    .region_sel_n (region_sel_n),
    .enable_wr    (enable_wr),
    .enable_wdata (enable_wdata),
    .same_page_n  (same_page_n),
    .en_q         (en_q),
    .busy_q       (busy_q)
);

// File: tb/test_page_match_detector.sv
module test_page_match_detector;
    localparam int AW = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strobe_n = 1'b1;
    logic          ready_n = 1'b1;
    logic          region_sel_n = 1'b1;
    logic          mask_wr = 1'b0;
    logic [AW-1:0] mask_wdata = '0;
    logic          enable_wr = 1'b0;
    logic          enable_wdata = 1'b0;
    logic          same_page_n;

    int total = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    page_match_detector i_page_match_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .strobe_n     (strobe_n),
        .ready_n      (ready_n),
        .region_sel_n (region_sel_n),
        .mask_wr      (mask_wr),
        .mask_wdata   (mask_wdata),
        .enable_wr    (enable_wr),
        .enable_wdata (enable_wdata),
        .same_page_n  (same_page_n)
    );

    // behavioural reference model
    bit            m_en, m_busy, m_hit, m_valid;
    logic [AW-1:0] m_mask, m_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_hit = 0; m_valid = 0;
            m_mask = '1; m_prev = '0;
        end else begin
            if (!strobe_n && !m_busy) begin
                m_busy = 1;
                if (!region_sel_n && m_en) begin
                    m_hit = m_valid && (((addr ^ m_prev) & m_mask) == '0);
                    m_prev = addr;
                    m_valid = 1;
                end else m_hit = 0;
            end else if (m_busy && !ready_n) begin
                m_busy = 0;
                m_hit = 0;
            end
            if (mask_wr) m_mask = mask_wdata;
            if (enable_wr) m_en = enable_wdata;
            if (!m_en) begin
                m_hit = 0;
                m_valid = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (same_page_n !== !m_hit) begin
                fails++;
                $display("FAIL model R4/R6 per-cycle: actual=%b expected=%b", same_page_n, !m_hit);
            end
        end
    end

    task automatic check(input logic exp_n, input string req);
        total++;
        if (same_page_n !== exp_n) begin
            fails++;
            $display("FAIL %s: same_page_n actual=%b expected=%b", req, same_page_n, exp_n);
        end
    endtask

    task automatic write_mask(input logic [AW-1:0] v);
        mask_wr = 1; mask_wdata = v;
        @(negedge clk);
        mask_wr = 0;
    endtask

    task automatic write_en(input logic v);
        enable_wr = 1; enable_wdata = v;
        @(negedge clk);
        enable_wr = 0;
    endtask

    task automatic access(input logic [AW-1:0] a, input logic cs_n, input int hold,
                          input bit exp_low, input string req);
        strobe_n = 0; addr = a; region_sel_n = cs_n;
        @(negedge clk);
        strobe_n = 1; region_sel_n = 1;
        check(!exp_low, req);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(!exp_low, "R6");
        end
        ready_n = 0;
        @(negedge clk);
        ready_n = 1;
        check(1'b1, "R6");
    endtask

    localparam logic [AW-1:0] A = 26'h0123450;
    localparam logic [AW-1:0] B = 26'h2000000;

    initial begin
        repeat (3) @(negedge clk);
        check(1'b1, "R1");
        rst_n = 1;
        @(negedge clk);
        check(1'b1, "R1");
        access(A, 0, 1, 0, "R2");
        access(A, 0, 0, 0, "R2");
        write_en(1);
        access(A, 0, 0, 0, "R7");
        access(A, 0, 3, 1, "R4");
        write_mask(26'h3FFFFF0);
        access(A | 26'h5, 0, 1, 1, "R5");
        access(A ^ 26'h100, 0, 0, 0, "R5");
        access(A ^ 26'h100, 1, 0, 0, "R3");
        access(A, 1, 0, 0, "R3");
        access(A ^ 26'h100, 0, 0, 1, "R3");
        access(B, 0, 0, 0, "R8");
        access(B, 0, 0, 1, "R8");
        // R10: strobe kept low inside an open cycle with another address
        strobe_n = 0; addr = B; region_sel_n = 0;
        @(negedge clk);
        check(1'b0, "R10");
        addr = A;
        @(negedge clk);
        check(1'b0, "R10");
        @(negedge clk);
        check(1'b0, "R10");
        strobe_n = 1; region_sel_n = 1; ready_n = 0;
        @(negedge clk);
        ready_n = 1;
        check(1'b1, "R10");
        access(B, 0, 0, 1, "R10");
        // R9: mask write effective on the next strobe
        write_mask('1);
        access(B | 26'h1, 0, 0, 0, "R9");
        // R9: enable cleared inside a cycle
        strobe_n = 0; addr = B | 26'h1; region_sel_n = 0;
        @(negedge clk);
        strobe_n = 1; region_sel_n = 1;
        check(1'b0, "R4");
        write_en(0);
        check(1'b1, "R9");
        ready_n = 0;
        @(negedge clk);
        ready_n = 1;
        check(1'b1, "R9");
        write_en(1);
        access(B | 26'h1, 0, 0, 0, "R7");
        access(B | 26'h1, 0, 2, 1, "R4");
        // R1: reset restores mask of all ones and disables
        rst_n = 0;
        @(negedge clk);
        check(1'b1, "R1");
        rst_n = 1;
        @(negedge clk);
        access(A, 0, 0, 0, "R1");
        write_en(1);
        access(A, 0, 0, 0, "R7");
        access(A | 26'h1, 0, 0, 0, "R1");
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            total++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule